// File: doc/BRIEF.md
# 16-bit Effective Address Decoder

This block parses the addressing part of an instruction one byte at a time and turns it into a 16-bit effective address. The first byte it accepts is the operand-descriptor byte. That byte has three fields: a two-bit mode in bits 7:6, a three-bit auxiliary field in bits 5:3, and a three-bit base/index selector in bits 2:0. Depending on the mode, the block then takes zero, one or two displacement bytes, least significant byte first. It then adds the selected pointer and index register values, which it reads from a register-value input bus, to the displacement.

Mode 3 names a register operand instead of a memory location. In that case no displacement is read, and the block reports the register number instead of an address. The combination mode 0 with selector 6 is a special case: it is an absolute address. It always carries a two-byte displacement, and no register is added.

An instruction decoder upstream feeds bytes through a valid/ready handshake. It watches for the one-cycle done pulse and takes the address, the register-operand flag and number, the auxiliary field, and the byte count. It uses the count to advance its own fetch pointer. The register-value bus is sampled during the done cycle.

Top module: `ea16_decoder`

## Requirements
- R1: In the done cycle, `spare` equals bits 5:3 of the descriptor byte, and that field has no effect on `ea`.
- R2: A descriptor with bits 7:6 = 3 ends the operand right away. Done rises in the cycle after that byte is accepted, with `is_reg`=1, `reg_num` = bits 2:0, `byte_cnt`=1 and `ea`=0.
- R3: Mode 0 with a selector other than 6 reads no displacement. `byte_cnt`=1, and `ea` is the register sum alone.
- R4: Mode 1 reads one displacement byte. That byte is sign-extended (bit 7 copied into bits 15:8) before it is added, and `byte_cnt`=2.
- R5: Mode 2 reads two displacement bytes, low byte first, and adds them as a 16-bit value. `byte_cnt`=3.
- R6: The selector picks the register sum: 0 gives BX+SI, 1 gives BX+DI, 2 gives BP+SI, 3 gives BP+DI, 4 gives SI, 5 gives DI, 6 gives BP, and 7 gives BX.
- R7: Mode 0 with selector 6 reads two displacement bytes (low first). `ea` equals that 16-bit value with no register added, and `byte_cnt`=3.
- R8: The address sum wraps modulo 65536.
- R9: Done is high for exactly one cycle after the last byte of an operand is accepted. `in_ready` is low during that cycle and high again in the next.
- R10: While reset is held, and right after it, `done`=0 and `in_ready`=1.
- R11: A cycle with `in_valid` low consumes no byte and does not change the parser's progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream: byte present |
| in_byte | input | 8 | Byte stream: data |
| in_ready | output | 1 | Byte stream: block can accept |
| reg_bx | input | 16 | Current BX value |
| reg_bp | input | 16 | Current BP value |
| reg_si | input | 16 | Current SI value |
| reg_di | input | 16 | Current DI value |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address (0 for a register operand) |
| is_reg | output | 1 | Operand is a register, not memory |
| reg_num | output | 3 | Register number for a register operand |
| spare | output | 3 | Auxiliary field of the descriptor byte |
| byte_cnt | output | 2 | Bytes consumed for this operand (1 to 3) |

## Verification
A parser that has lost its place shows up at the ports within one byte. The done pulse arrives a cycle early or late against the byte count, `in_ready` drops in the wrong cycle, and the next descriptor is taken from a displacement byte. That corrupts every later result. A wrong register selection, a missing sign extension, or a swapped displacement byte order shows up only in `ea`, in the done cycle of the affected operand. So the model predicts the handshake in every cycle, and the address fields in every done cycle, over all mode and selector pairs with idle gaps in the stream.

// File: rtl/ea16_pkg.sv
package ea16_pkg;

   typedef enum logic [1:0] {
      ST_DESC    = 2'd0,
      ST_DISP_LO = 2'd1,
      ST_DISP_HI = 2'd2,
      ST_DONE    = 2'd3
   } ea_state_t;

   typedef enum logic [1:0] {
      DISP_NONE = 2'd0,
      DISP_BYTE = 2'd1,
      DISP_WORD = 2'd2
   } disp_kind_t;

   // descriptor byte layout: the field positions are fixed by the encoding
   typedef struct packed {
      logic [1:0] mode;
      logic [2:0] spare;
      logic [2:0] sel;
   } desc_t;

   localparam logic [1:0] MODE_NODISP = 2'd0;
   localparam logic [1:0] MODE_BYTE   = 2'd1;
   localparam logic [1:0] MODE_WORD   = 2'd2;
   localparam logic [1:0] MODE_REG    = 2'd3;
   localparam logic [2:0] SEL_ABS     = 3'd6;

   function automatic disp_kind_t disp_kind_of(input logic [1:0] mode, input logic [2:0] sel);
      disp_kind_t k;
      case (mode)
         MODE_BYTE:   k = DISP_BYTE;
         MODE_WORD:   k = DISP_WORD;
         MODE_NODISP: k = (sel == SEL_ABS) ? DISP_WORD : DISP_NONE;
         default:     k = DISP_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ea16_byte_fsm.sv
module ea16_byte_fsm
   import ea16_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_byte,
   output logic                  in_ready,
   output logic                  done,
   output desc_t                 desc_q,
   output logic [2*DATA_W-1:0]   disp_q,
   output logic [CNT_W-1:0]      byte_cnt
);

   ea_state_t  state;
   logic       need_word;
   disp_kind_t kind_in;
   desc_t      desc_in;

   assign desc_in  = desc_t'(in_byte);
   assign kind_in  = disp_kind_of(desc_in.mode, desc_in.sel);
   assign in_ready = (state != ST_DONE);
   assign done     = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_DESC;
         need_word <= 1'b0;
         desc_q    <= '0;
         disp_q    <= '0;
         byte_cnt  <= '0;
      end else begin
         case (state)
            ST_DESC: if (in_valid) begin
               desc_q    <= desc_in;
               disp_q    <= '0;
               byte_cnt  <= CNT_W'(1);
               need_word <= (kind_in == DISP_WORD);
               state     <= (kind_in == DISP_NONE) ? ST_DONE : ST_DISP_LO;
            end
            ST_DISP_LO: if (in_valid) begin
               disp_q[DATA_W-1:0] <= in_byte;
               byte_cnt           <= byte_cnt + CNT_W'(1);
               state              <= need_word ? ST_DISP_HI : ST_DONE;
            end
            ST_DISP_HI: if (in_valid) begin
               disp_q[2*DATA_W-1:DATA_W] <= in_byte;
               byte_cnt                  <= byte_cnt + CNT_W'(1);
               state                     <= ST_DONE;
            end
            default: state <= ST_DESC;
         endcase
      end
   end

   // an idle cycle leaves the parser where it was
   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_DONE && !in_valid) |=> (state == $past(state) && byte_cnt == $past(byte_cnt)));

   // the strobe lasts one cycle and the stream reopens after it
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && in_ready));

endmodule

// File: rtl/ea16_addr_gen.sv
module ea16_addr_gen
   import ea16_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit SEXT_DISP8 = 1'b1
) (
   input  logic [1:0]          mode,
   input  logic [2:0]          sel,
   input  logic [ADDR_W-1:0]   disp,
   input  logic [ADDR_W-1:0]   reg_bx,
   input  logic [ADDR_W-1:0]   reg_bp,
   input  logic [ADDR_W-1:0]   reg_si,
   input  logic [ADDR_W-1:0]   reg_di,
   output logic [ADDR_W-1:0]   ea
);

   localparam int EXT_W = ADDR_W - DATA_W;

   disp_kind_t        kind;
   logic [ADDR_W-1:0] disp_short;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] base_v;
   logic [ADDR_W-1:0] index_v;
   logic              absolute;

   assign kind     = disp_kind_of(mode, sel);
   assign absolute = (mode == MODE_NODISP) && (sel == SEL_ABS);

   generate
      if (SEXT_DISP8) begin : g_sext
         assign disp_short = {{EXT_W{disp[DATA_W-1]}}, disp[DATA_W-1:0]};
      end else begin : g_zext
         assign disp_short = {{EXT_W{1'b0}}, disp[DATA_W-1:0]};
      end
   endgenerate

   always_comb begin
      case (kind)
         DISP_BYTE: disp_ext = disp_short;
         DISP_WORD: disp_ext = disp;
         default:   disp_ext = '0;
      endcase
   end

   // base half of the sum: BX for selectors 0,1,7; BP for 2,3,6
   always_comb begin
      base_v = '0;
      if (!absolute) begin
         case (sel)
            3'd0, 3'd1, 3'd7: base_v = reg_bx;
            3'd2, 3'd3, 3'd6: base_v = reg_bp;
            default:          base_v = '0;
         endcase
      end
   end

   // index half: SI for selectors 0,2,4; DI for 1,3,5
   always_comb begin
      case (sel)
         3'd0, 3'd2, 3'd4: index_v = reg_si;
         3'd1, 3'd3, 3'd5: index_v = reg_di;
         default:          index_v = '0;
      endcase
   end

   // ADDR_W-bit sum: wraps naturally
   assign ea = base_v + index_v + disp_ext;

endmodule

// File: rtl/ea16_decoder.sv
module ea16_decoder
   import ea16_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit SEXT_DISP8 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] reg_bx,
   input  logic [ADDR_W-1:0] reg_bp,
   input  logic [ADDR_W-1:0] reg_si,
   input  logic [ADDR_W-1:0] reg_di,
   output logic              done,
   output logic [ADDR_W-1:0] ea,
   output logic              is_reg,
   output logic [2:0]        reg_num,
   output logic [2:0]        spare,
   output logic [1:0]        byte_cnt
);

   localparam int CNT_W = 2;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("ea16_decoder: DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("ea16_decoder: ADDR_W must be twice DATA_W");
      end
   endgenerate

   desc_t             desc_q;
   logic [ADDR_W-1:0] disp_q;
   logic [ADDR_W-1:0] ea_mem;

   ea16_byte_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_ready (in_ready),
      .done     (done),
      .desc_q   (desc_q),
      .disp_q   (disp_q),
      .byte_cnt (byte_cnt)
   );

   ea16_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEXT_DISP8(SEXT_DISP8)) u_addr (
      .mode   (desc_q.mode),
      .sel    (desc_q.sel),
      .disp   (disp_q),
      .reg_bx (reg_bx),
      .reg_bp (reg_bp),
      .reg_si (reg_si),
      .reg_di (reg_di),
      .ea     (ea_mem)
   );

   assign is_reg  = (desc_q.mode == MODE_REG);
   assign reg_num = desc_q.sel;
   assign spare   = desc_q.spare;
   assign ea      = is_reg ? '0 : ea_mem;

   assert_reg_single_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_reg) |-> (byte_cnt == 2'd1 && ea == '0));

   assert_abs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && desc_q.mode == MODE_NODISP && desc_q.sel == SEL_ABS) |-> (byte_cnt == 2'd3 && ea == disp_q));

   assert_byte_disp_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && desc_q.mode == MODE_BYTE) |-> (byte_cnt == 2'd2));

   assert_word_disp_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && desc_q.mode == MODE_WORD) |-> (byte_cnt == 2'd3));

endmodule

// File: tb/tb_ea16_decoder.sv
`timescale 1ns/1ps
module tb_ea16_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready;
   logic [15:0] reg_bx = 16'hFFF0, reg_bp = 16'hC001, reg_si = 16'h0025, reg_di = 16'h8000;
   logic        done;
   logic [15:0] ea;
   logic        is_reg;
   logic [2:0]  reg_num;
   logic [2:0]  spare;
   logic [1:0]  byte_cnt;

   always #2.5 clk = ~clk;

   ea16_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .done(done), .ea(ea), .is_reg(is_reg), .reg_num(reg_num), .spare(spare), .byte_cnt(byte_cnt)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [7:0]  q[$];
   int          ph = 0;      // 0 descriptor, 1 low disp, 2 high disp, 3 done
   int          need = 0;
   int          cnt = 0;
   int          dsp = 0;
   logic [7:0]  mb = 8'h00;
   int          cyc = 0;
   bit          started = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic add(input logic [1:0] md, input logic [2:0] sp, input logic [2:0] rm,
                      input logic [7:0] d0, input logic [7:0] d1);
      q.push_back({md, sp, rm});
      if (md == 2'd1) q.push_back(d0);
      if (md == 2'd2 || (md == 2'd0 && rm == 3'd6)) begin
         q.push_back(d0);
         q.push_back(d1);
      end
   endtask

   function automatic logic [15:0] ref_ea(input logic [7:0] d, input int disp);
      int s;
      logic [31:0] t;
      if (d[7:6] == 2'd0 && d[2:0] == 3'd6) s = disp;
      else begin
         case (d[2:0])   // R6 selector table
            3'd0: s = int'(reg_bx) + int'(reg_si);
            3'd1: s = int'(reg_bx) + int'(reg_di);
            3'd2: s = int'(reg_bp) + int'(reg_si);
            3'd3: s = int'(reg_bp) + int'(reg_di);
            3'd4: s = int'(reg_si);
            3'd5: s = int'(reg_di);
            3'd6: s = int'(reg_bp);
            default: s = int'(reg_bx);
         endcase
         s = s + disp;
      end
      t = s;           // R8: keep only the low 16 bits
      return t[15:0];
   endfunction

   // reference model: advances on the same handshake the design sees
   always @(posedge clk) begin
      if (!rst_n) ph = 0;
      else if (ph == 3) ph = 0;
      else if (in_valid) begin
         logic [7:0] b;
         b = q.pop_front();
         if (ph == 0) begin
            mb = b; cnt = 1; dsp = 0;
            if (b[7:6] == 2'd3 || (b[7:6] == 2'd0 && b[2:0] != 3'd6)) ph = 3;
            else begin
               need = (b[7:6] == 2'd1) ? 1 : 2;
               ph = 1;
            end
         end else if (ph == 1) begin
            cnt++;
            if (need == 1) begin
               dsp = (b >= 8'd128) ? int'(b) - 256 : int'(b);
               ph = 3;
            end else begin
               dsp = int'(b);
               ph = 2;
            end
         end else begin
            cnt++;
            dsp = dsp + int'(b) * 256;
            ph = 3;
         end
      end
   end

   // compare away from the active edge, then drive the next inputs
   always @(negedge clk) begin
      if (started) begin
         chk(in_ready == (ph != 3), "R9 R11", "in_ready", in_ready, ph != 3);
         chk(done == (ph == 3), "R9 R11", "done", done, ph == 3);
         if (ph == 3) begin
            string tag;
            case (mb[7:6])
               2'd3: tag = "R2";
               2'd1: tag = "R4";
               2'd2: tag = "R5";
               default: tag = (mb[2:0] == 3'd6) ? "R7" : "R3";
            endcase
            chk(spare == mb[5:3], "R1", "spare", spare, mb[5:3]);
            chk(byte_cnt == cnt[1:0], tag, "byte_cnt", byte_cnt, cnt);
            chk(is_reg == (mb[7:6] == 2'd3), "R2", "is_reg", is_reg, mb[7:6] == 2'd3);
            if (mb[7:6] == 2'd3) begin
               chk(reg_num == mb[2:0], "R2", "reg_num", reg_num, mb[2:0]);
               chk(ea == 16'h0, "R2", "ea", ea, 0);
            end else begin
               logic [15:0] e;
               e = ref_ea(mb, dsp);
               chk(ea == e, {tag, " R6 R8 R1"}, "ea", ea, e);
            end
            seed = seed * 32'd1664525 + 32'd1013904223;
            reg_bx = seed[31:16];
            reg_si = seed[15:0];
            seed = seed * 32'd1664525 + 32'd1013904223;
            reg_bp = seed[31:16];
            reg_di = seed[15:0];
         end
         in_valid = (q.size() > 0) && (cyc % 7 != 5);   // R11 idle gaps
         in_byte  = (q.size() > 0) ? q[0] : 8'h00;
         cyc++;
      end
   end

   initial begin
      logic [31:0] s;
      s = 32'hCAFE_0001;
      for (int rep = 0; rep < 3; rep++) begin
         for (int md = 0; md < 4; md++) begin
            for (int rm = 0; rm < 8; rm++) begin
               s = s * 32'd1664525 + 32'd1013904223;
               add(md[1:0], s[10:8], rm[2:0], s[23:16], s[31:24]);
            end
         end
      end
      add(2'd1, 3'd0, 3'd7, 8'h80, 8'h00);   // R4 most negative byte
      add(2'd1, 3'd2, 3'd4, 8'hFF, 8'h00);   // R4 minus one
      add(2'd0, 3'd5, 3'd6, 8'h00, 8'h00);   // R7 absolute zero
      add(2'd0, 3'd7, 3'd6, 8'h34, 8'h12);   // R7 byte order
      add(2'd2, 3'd1, 3'd0, 8'hFF, 8'hFF);   // R5 R8 wrap

      repeat (3) @(negedge clk);
      chk(done == 1'b0 && in_ready == 1'b1, "R10", "reset done/ready", {done, in_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && in_ready == 1'b1, "R10", "after reset done/ready", {done, in_ready}, 2'b01);
      started = 1'b1;

      begin : run
         for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && ph == 0) disable run;
         end
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule